// File: doc/BRIEF.md
# Quadrature Position Decoder with Fast Mode

The block turns two phase-shifted encoder signals into a bidirectional position count. Channel A is the primary input and channel B the secondary. Both inputs are assumed to be synchronised to `clk` already. A free-running timebase advances once per clock. Every accepted edge records the timebase value, so host software can interpolate position when the encoder turns slowly.

In normal mode, every transition on either channel is serviced and moves the count by one. The direction comes from comparing the new level of the channel that moved with the stored level of the other channel. At high speed the host can set a mode bit. The next rising edge of A then switches the block into fast mode. In fast mode B is ignored and only rising edges of A are counted, each one moving the count by four in the last known direction. When the host clears the mode bit, the next rising edge of A returns the block to normal mode and resynchronises the stored level of B.

The host side is a small register file with a write port and a separate combinational read port. Address 0 is control: write bit 0 is the mode bit, bit 1 is the initialise command and bit 2 is the timebase snapshot command; read bit 0 is the mode bit, bit 1 is fast-mode-active and bit 2 is the last direction (1 = up). Address 1 is the position, 2 is the edge time, 3 is the snapshot, 4 is the stored A level and 5 is the stored B level.

Top module: `quad_decoder_fm`

## Requirements
- R1: After reset the position, edge time, both stored levels and the control read value are all zero.
- R2: In normal mode, with A leading B (sequence 00,10,11,01,00 as AB) each edge adds 1 and the direction bit reads 1. With B leading A each edge subtracts 1 and the direction bit reads 0.
- R3: The position is 16 bits wide and wraps modulo 2^16 in both directions.
- R4: A transition whose new level equals the stored level of that channel is discarded as noise. The position and the edge time do not change.
- R5: Each stored level reads as 0x8000 for high and 0x0000 for low. The host can preset it at address 4 (A) or 5 (B) with bit 15 of the write data.
- R6: An accepted edge latches the timebase into the edge-time register. The snapshot command latches the timebase into the snapshot register. Both latch the same value when they occur in the same cycle, and two snapshots N cycles apart differ by N.
- R7: The initialise command loads both stored levels from the current pins and leaves fast mode. It keeps the mode bit and the position unchanged.
- R8: Fast mode is entered only by an accepted rising edge of A while the mode bit is set. That edge itself steps the count by ±1.
- R9: In fast mode each rising edge of A steps the count by 4 in the remembered direction. Falling edges of A and every transition of B are ignored.
- R10: With the mode bit clear, the next rising edge of A in fast mode steps by 4, leaves fast mode and sets the stored B level to the B pin. Normal counting then resumes.
- R11: A host write to the position takes priority over a count update in the same cycle, and that update is dropped.
- R12: When A and B change in the same cycle in normal mode, A is serviced in that cycle and B in the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_a | input | 1 | Primary encoder channel, already synchronised |
| ch_b | input | 1 | Secondary encoder channel, already synchronised |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 3 | Host write register address |
| host_wdata | input | W | Host write data |
| host_raddr | input | 3 | Host read register address |
| host_rdata | output | W | Host read data, combinational from host_raddr |

## Verification
The bench builds the block with its default values: W = 16 and a fast step of 4. With the 16-bit width, a single backward edge from zero reaches the wrap boundary. With the step of 4, fast-mode increments are easy to tell apart from normal ones. Fast-mode entry and exit are driven in both directions, including an initialise command issued while fast mode is active.

// File: rtl/quad_decoder_fm.sv
module quad_decoder_fm #(
  parameter int W = 16,
  parameter int FAST_STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ch_a,
  input  logic         ch_b,
  input  logic         host_we,
  input  logic [2:0]   host_waddr,
  input  logic [W-1:0] host_wdata,
  input  logic [2:0]   host_raddr,
  output logic [W-1:0] host_rdata
);
  localparam logic [W-1:0] STEP_F = W'(FAST_STEP);
  localparam logic [W-1:0] STEP_N = W'(1);

  logic a_q, b_q, lvl_a, lvl_b, fm_en, in_fast, dir_up, pend_b;
  logic [W-1:0] pos, edge_t, snap_t, tb;

  wire wr_ctrl = host_we && host_waddr == 3'd0;
  wire wr_pos  = host_we && host_waddr == 3'd1;
  wire wr_la   = host_we && host_waddr == 3'd4;
  wire wr_lb   = host_we && host_waddr == 3'd5;
  wire init_cmd = wr_ctrl && host_wdata[1];
  wire snap_cmd = wr_ctrl && host_wdata[2];

  wire trans_a = ch_a ^ a_q;
  wire trans_b = ch_b ^ b_q;
  wire norm_a  = !in_fast && trans_a;
  wire ev_b    = !in_fast && (trans_b || pend_b);
  wire svc_b   = ev_b && !norm_a;
  wire acc_a   = norm_a && (ch_a != lvl_a);
  wire acc_b   = svc_b && (ch_b != lvl_b);
  wire fast_hit = in_fast && trans_a && ch_a;

  wire step_n  = acc_a || acc_b;
  wire step_up = acc_a ? (ch_a ^ lvl_b) : !(ch_b ^ lvl_a);
  wire enter_fast = acc_a && ch_a && fm_en;
  wire leave_fast = fast_hit && !fm_en;
  wire any_edge   = (step_n || fast_hit) && !init_cmd;

  logic [W-1:0] delta;
  always_comb begin
    if (fast_hit) delta = dir_up ? STEP_F : -STEP_F;
    else          delta = step_up ? STEP_N : -STEP_N;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0; b_q <= 1'b0; lvl_a <= 1'b0; lvl_b <= 1'b0;
      fm_en <= 1'b0; in_fast <= 1'b0; dir_up <= 1'b0; pend_b <= 1'b0;
      pos <= '0; edge_t <= '0; snap_t <= '0; tb <= '0;
    end else begin
      a_q <= ch_a;
      b_q <= ch_b;
      tb  <= tb + STEP_N;
      if (wr_ctrl) fm_en <= host_wdata[0];
      if (snap_cmd) snap_t <= tb;
      if (init_cmd) begin
        lvl_a <= ch_a;
        lvl_b <= ch_b;
        in_fast <= 1'b0;
        pend_b <= 1'b0;
      end else begin
        pend_b <= ev_b && !svc_b && !enter_fast;
        if (acc_a) lvl_a <= ch_a;
        if (acc_b) lvl_b <= ch_b;
        if (step_n) dir_up <= step_up;
        if (enter_fast) in_fast <= 1'b1;
        if (leave_fast) begin
          in_fast <= 1'b0;
          lvl_b <= ch_b;
        end
        if (any_edge) edge_t <= tb;
      end
      if (wr_la) lvl_a <= host_wdata[W-1];
      if (wr_lb) lvl_b <= host_wdata[W-1];
      if (wr_pos) pos <= host_wdata;
      else if (any_edge) pos <= pos + delta;
    end
  end

  always_comb begin
    case (host_raddr)
      3'd0:    host_rdata = {{(W-3){1'b0}}, dir_up, in_fast, fm_en};
      3'd1:    host_rdata = pos;
      3'd2:    host_rdata = edge_t;
      3'd3:    host_rdata = snap_t;
      3'd4:    host_rdata = {lvl_a, {(W-1){1'b0}}};
      3'd5:    host_rdata = {lvl_b, {(W-1){1'b0}}};
      default: host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/quad_decoder_fm_chk.sv
module quad_decoder_fm_chk #(
  parameter int W = 16,
  parameter int STEP = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_we,
  input logic [2:0]   host_waddr,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] pos,
  input logic         in_fast,
  input logic         fm_en,
  input logic         lvl_b
);
  wire wr_pos = host_we && host_waddr == 3'd1;
  wire wr_lb  = host_we && host_waddr == 3'd5;

  p_norm_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(in_fast) && !$past(wr_pos)) |->
      (pos == $past(pos) || pos == $past(pos) + W'(1) || pos == $past(pos) - W'(1)));

  p_fast_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_fast) && !$past(wr_pos) && pos != $past(pos)) |->
      (pos == $past(pos) + W'(STEP) || pos == $past(pos) - W'(STEP)));

  p_b_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_fast) && in_fast && !$past(wr_lb)) |-> $stable(lvl_b));

  p_host_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_pos) |-> pos == $past(host_wdata));

  p_enter_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_fast) |-> $past(fm_en));
endmodule

bind quad_decoder_fm quad_decoder_fm_chk #(.W(W), .STEP(FAST_STEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
  .host_wdata(host_wdata), .pos(pos), .in_fast(in_fast), .fm_en(fm_en),
  .lvl_b(lvl_b)
);

// File: tb/quad_decoder_fm_test.sv
module quad_decoder_fm_test;
  localparam int W = 16;
  logic clk = 1'b0, rst_n = 1'b0, ch_a = 1'b0, ch_b = 1'b0;
  logic host_we = 1'b0;
  logic [2:0] host_waddr = '0, host_raddr = '0;
  logic [W-1:0] host_wdata = '0, host_rdata;
  int total = 0, fails = 0;
  logic [W-1:0] exp_pos = '0;
  logic [W-1:0] s1, s2, e0;

  typedef struct { string tag; logic [2:0] addr; logic [W-1:0] val; } item_t;
  item_t sb[$];

  quad_decoder_fm #(.W(W), .FAST_STEP(4)) uut (
    .clk(clk), .rst_n(rst_n), .ch_a(ch_a), .ch_b(ch_b),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      item_t it;
      while (sb.size() == 0) #1;
      it = sb.pop_front();
      host_raddr = it.addr;
      #1;
      total++;
      if (host_rdata !== it.val) begin
        fails++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, host_rdata, it.val);
      end
    end
  end

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  task automatic chk(input string tag, input logic [2:0] a, input logic [W-1:0] v);
    item_t it;
    it.tag = tag; it.addr = a; it.val = v;
    sb.push_back(it);
  endtask

  task automatic settle();
    while (sb.size() != 0) #1;
    #2;
  endtask

  task automatic get(input logic [2:0] a, output logic [W-1:0] v);
    host_raddr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    ch_a = a; ch_b = b;
    @(negedge clk);
  endtask

  task automatic step(input logic a, input logic b, input logic [W-1:0] d, input string tag);
    pins(a, b);
    exp_pos = exp_pos + d;
    chk(tag, 3'd1, exp_pos);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 pos", 3'd1, 16'h0); chk("R1 edge", 3'd2, 16'h0);
    chk("R1 lvl_a", 3'd4, 16'h0); chk("R1 ctrl", 3'd0, 16'h0);
    settle();
    chk("R1 lvl_b", 3'd5, 16'h0); settle();
    // R2 A leads B: up
    step(1, 0, 16'd1, "R2 up"); step(1, 1, 16'd1, "R2 up");
    step(0, 1, 16'd1, "R2 up"); step(0, 0, 16'd1, "R2 up");
    chk("R2 dir up", 3'd0, 16'h4); settle();
    // R2 B leads A: down
    step(0, 1, -16'd1, "R2 down"); step(1, 1, -16'd1, "R2 down");
    step(1, 0, -16'd1, "R2 down"); step(0, 0, -16'd1, "R2 down");
    chk("R2 dir down", 3'd0, 16'h0); settle();
    // R3 wrap below zero and back
    step(0, 1, -16'd1, "R3 wrap");
    chk("R3 wrap value", 3'd1, 16'hFFFF);
    chk("R5 lvl_b high", 3'd5, 16'h8000); settle();
    step(0, 0, 16'd1, "R3 wrap back");
    // R6 edge and snapshot in the same cycle
    @(negedge clk);
    ch_a = 1'b1; host_we = 1'b1; host_waddr = 3'd0; host_wdata = 16'h4;
    @(negedge clk);
    host_we = 1'b0;
    exp_pos = exp_pos + 16'd1;
    chk("R6 pos", 3'd1, exp_pos); settle();
    get(3'd3, s1);
    chk("R6 edge==snap", 3'd2, s1); settle();
    step(0, 0, -16'd1, "R2 A fall");
    // R6 snapshot spacing
    wr(3'd0, 16'h4); get(3'd3, s1);
    repeat (5) @(negedge clk);
    wr(3'd0, 16'h4); get(3'd3, s2);
    total++;
    if (s2 - s1 !== 16'd7) begin
      fails++;
      $display("FAIL R6 snapshot spacing actual=%0d expected=7", s2 - s1);
    end
    // R4 noise: preset A high, raise A
    get(3'd2, e0);
    wr(3'd4, 16'h8000);
    chk("R5 preset lvl_a", 3'd4, 16'h8000); settle();
    step(1, 0, 16'd0, "R4 noise pos");
    chk("R4 noise edge", 3'd2, e0); settle();
    step(0, 0, -16'd1, "R4 next edge accepted");
    chk("R5 lvl_a low", 3'd4, 16'h0); settle();
    wr(3'd1, 16'h0); exp_pos = '0;
    chk("R11 plain write", 3'd1, 16'h0); settle();
    // R7 init reloads levels from pins
    wr(3'd4, 16'h8000); wr(3'd5, 16'h8000);
    chk("R5 lvl_b preset", 3'd5, 16'h8000); settle();
    wr(3'd0, 16'h2);
    chk("R7 lvl_a", 3'd4, 16'h0); chk("R7 lvl_b", 3'd5, 16'h0);
    chk("R7 pos", 3'd1, exp_pos); settle();
    // R12 simultaneous transitions
    pins(1, 1);
    exp_pos = exp_pos + 16'd1;
    chk("R12 A first", 3'd1, exp_pos); settle();
    @(negedge clk);
    exp_pos = exp_pos + 16'd1;
    chk("R12 B next", 3'd1, exp_pos); settle();
    pins(0, 0);
    @(negedge clk);
    exp_pos = exp_pos + 16'd2;
    chk("R12 both fall", 3'd1, exp_pos); settle();
    // R11 host write beats edge
    @(negedge clk);
    ch_a = 1'b1; host_we = 1'b1; host_waddr = 3'd1; host_wdata = 16'h1234;
    @(negedge clk);
    host_we = 1'b0; exp_pos = 16'h1234;
    chk("R11 write wins", 3'd1, 16'h1234);
    chk("R11 level still taken", 3'd4, 16'h8000); settle();
    step(0, 0, -16'd1, "R11 after");
    // R8 no fast entry without mode bit
    step(1, 0, 16'd1, "R8 normal rise");
    chk("R8 not fast", 3'd0, 16'h4); settle();
    step(0, 0, -16'd1, "R8 fall");
    wr(3'd0, 16'h1);
    step(1, 0, 16'd1, "R8 entry step");
    chk("R8 in fast", 3'd0, 16'h7); settle();
    // R9 fast counting
    step(0, 0, 16'd0, "R9 A fall ignored");
    step(0, 1, 16'd0, "R9 B ignored");
    chk("R9 lvl_b kept", 3'd5, 16'h0); settle();
    step(1, 1, 16'd4, "R9 up by 4");
    step(0, 1, 16'd0, "R9 ignored");
    step(0, 0, 16'd0, "R9 ignored");
    step(1, 0, 16'd4, "R9 up by 4");
    // R10 exit
    wr(3'd0, 16'h0);
    chk("R10 still fast", 3'd0, 16'h6); settle();
    step(0, 0, 16'd0, "R10 fall ignored");
    step(0, 1, 16'd0, "R10 B ignored");
    step(1, 1, 16'd4, "R10 exit step");
    chk("R10 left fast", 3'd0, 16'h4);
    chk("R10 lvl_b resync", 3'd5, 16'h8000); settle();
    step(0, 1, 16'd1, "R10 normal resumes");
    // R9 fast mode downward
    step(0, 0, 16'd1, "R2 B fall");
    step(0, 1, -16'd1, "R2 B rise down");
    wr(3'd0, 16'h1);
    step(1, 1, -16'd1, "R8 entry down");
    chk("R8 fast down", 3'd0, 16'h3); settle();
    step(0, 1, 16'd0, "R9 ignored");
    step(1, 1, -16'd4, "R9 down by 4");
    // R7 init while fast
    wr(3'd0, 16'h3);
    chk("R7 leaves fast", 3'd0, 16'h1);
    chk("R7 lvl_a", 3'd4, 16'h8000); chk("R7 lvl_b", 3'd5, 16'h8000);
    chk("R7 pos kept", 3'd1, exp_pos); settle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule